// File: doc/BRIEF.md
# SPI Register Access Master

This block is an SPI master that performs one register transaction at a time against a peripheral. The peripheral has 8-bit register addresses and 32-bit registers. A host raises `start` for one cycle and supplies a direction flag, an address and, for writes, a data word. The block then runs a complete serial frame on `cs_n`, `sck` and `mosi`. While the frame is in progress `busy` is high. When the frame is over, `done` pulses for one cycle.

Each frame has three parts. First comes a command byte: 0 for a read, 1 for a write. Next is the address byte. Last is a 32-bit data word. All three are sent most significant bit first. On a write the master drives the data word on `mosi`. On a read the peripheral drives the data word on `miso`, and the master shifts it in and presents it on `rdata` in the same cycle as `done`.

The serial clock idles low. Bits are sampled on the rising edge and change on the falling edge (SPI mode 0). The SCK half-period is set per transaction from the `half_period` input, measured in system clocks. Values below a parameterised floor are raised to that floor.

Top module: `spi_regxfer`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, and `busy` and `done` are 0.
- R2: The first 8 SCK rising edges of a frame carry the command byte, MSB first: value 8'h00 for a read (`rd_wr`=0) and 8'h01 for a write (`rd_wr`=1). Rising edges 9 to 16 carry `addr`, MSB first.
- R3: In a write frame, rising edges 17 to 48 carry `wdata`, MSB first, on `mosi`.
- R4: In a read frame, the master samples `miso` on rising edges 17 to 48 and assembles the bits MSB first. The result appears on `rdata` in the cycle in which `done` is 1. A peripheral that returns 32'hB7AADA2F for address 0 yields exactly that value.
- R5: `sck` is 0 whenever `cs_n` is 1. `mosi` never changes while `sck` is high inside a frame.
- R6: Every SCK high phase lasts H system clocks, where H = max(`half_period`, MIN_HALF). H is captured at `start`, and MIN_HALF defaults to 4.
- R7: After the last falling SCK edge, `cs_n` returns high. It then stays high for at least 2·H system clocks before `done` is asserted.
- R8: A `start` pulse that arrives while `busy` is 1 is ignored. It produces no extra frame and no extra `done`.
- R9: `done` is high for exactly one cycle, and `busy` is 0 in that cycle. `busy` falls only together with `done`.
- R10: Every frame contains exactly 48 SCK rising edges while `cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a transaction |
| rd_wr | input | 1 | 0 = register read, 1 = register write |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| half_period | input | DIV_W | Requested SCK half-period in system clocks |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, valid with `done` on reads |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
A behavioural peripheral decodes each frame. It counts rising edges, so a design with an off-by-one edge count or a missing lead-in half-period would leave it with a wrong command, a wrong address or 47 or 49 edges. The peripheral loads read data on the falling edge after the 16th rise. A master that samples one edge early or late would therefore return the identification word shifted by one bit.

The bench checks the floor on the half-period with a request of 2 and also tests a longer value. It checks that a write to address 0 leaves the identification word intact. It fires `start` in the middle of a frame, which a design lacking the busy guard would turn into a corrupted or extra transaction. It also measures the chip-select gap, which a design that raised `done` early would cut short.

// File: rtl/spi_regxfer.sv
module spi_regxfer #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_wr,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [DIV_W-1:0] half_period,
  output logic             busy,
  output logic             done,
  output logic [31:0]      rdata,
  output logic             cs_n,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  localparam int FRAME_BITS = 48;
  localparam int LAST_HS    = 2 * FRAME_BITS;
  localparam int CAP_HS     = 32;
  localparam int HS_W       = $clog2(LAST_HS + 1);

  typedef enum logic [1:0] {IDLE, RUN, GAP} st_t;

  st_t                   st;
  logic [HS_W-1:0]       hs;
  logic [DIV_W-1:0]      cnt, hp;
  logic [FRAME_BITS-1:0] sh;
  logic [31:0]           cap;
  logic                  wr;
  logic [DIV_W-1:0]      hp_req;

  assign hp_req = (half_period < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_period;
  assign busy   = (st != IDLE);
  assign mosi   = sh[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; hs <= '0; cnt <= '0; hp <= '0; sh <= '0; cap <= '0;
      wr <= 1'b0; cs_n <= 1'b1; sck <= 1'b0; done <= 1'b0; rdata <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st   <= RUN;
          cs_n <= 1'b0;
          sck  <= 1'b0;
          hs   <= '0;
          hp   <= hp_req;
          cnt  <= hp_req - 1'b1;
          wr   <= rd_wr;
          sh   <= {7'd0, rd_wr, addr, rd_wr ? wdata : 32'd0};
        end
        RUN: if (cnt != 0) cnt <= cnt - 1'b1;
        else begin
          cnt <= hp - 1'b1;
          if (hs == HS_W'(LAST_HS)) begin
            cs_n <= 1'b1;
            st   <= GAP;
            hs   <= '0;
          end else begin
            hs  <= hs + 1'b1;
            sck <= ~hs[0];
            if (!hs[0]) begin
              if (!wr && hs >= HS_W'(CAP_HS)) cap <= {cap[30:0], miso};
            end else begin
              sh <= {sh[FRAME_BITS-2:0], 1'b0};
            end
          end
        end
        GAP: if (cnt != 0) cnt <= cnt - 1'b1;
        else begin
          cnt <= hp - 1'b1;
          if (hs[0]) begin
            st   <= IDLE;
            done <= 1'b1;
            if (!wr) rdata <= cap;
          end else begin
            hs <= hs + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && $past(sck)) |-> $stable(mosi));
  // R7
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && $past(busy)) |-> $stable(wr));
endmodule

// File: tb/spi_regxfer_bench.sv
module spi_regxfer_bench;
  localparam logic [31:0] ID_WORD = 32'hB7AADA2F;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 1'b0, rd_wr = 1'b0;
  logic [7:0] addr = '0, half_period = 8'd4;
  logic [31:0] wdata = '0;
  wire busy, done, cs_n, sck, mosi, miso;
  wire [31:0] rdata;

  spi_regxfer u_spi_regxfer (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_wr(rd_wr), .addr(addr),
    .wdata(wdata), .half_period(half_period), .busy(busy), .done(done),
    .rdata(rdata), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

  int checks = 0, errors = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] init_val(int i);
    return {i[7:0], ~i[7:0], 8'hC3, i[7:0]};
  endfunction

  // behavioural peripheral
  logic [31:0] smem [0:255];
  logic [31:0] shadow [0:255];
  logic [47:0] rx = '0;
  int nrise = 0;
  logic [31:0] tx = '0, s_wdata = '0;
  logic [7:0] s_cmd = '0, s_addr = '0;
  assign miso = cs_n ? 1'bz : tx[31];

  initial for (int i = 0; i < 256; i++) begin smem[i] = init_val(i); shadow[i] = init_val(i); end

  always @(negedge cs_n) begin nrise = 0; rx = '0; end
  always @(posedge sck) if (!cs_n) begin
    rx = {rx[46:0], mosi};
    nrise++;
    if (nrise == 16) begin s_cmd = rx[15:8]; s_addr = rx[7:0]; end
    if (nrise == 48 && s_cmd == 8'd1) begin
      s_wdata = rx[31:0];
      if (s_addr != 0) smem[s_addr] = rx[31:0];
    end
  end
  always @(negedge sck) if (!cs_n) begin
    if (nrise == 16 && s_cmd == 8'd0) tx = (s_addr == 0) ? ID_WORD : smem[s_addr];
    else tx = {tx[30:0], 1'b0};
  end

  // scoreboard
  typedef struct { bit wr; logic [7:0] a; logic [31:0] d; int hp; } item_t;
  item_t q[$];
  int cur_hp = 4, hcnt = 0, bad_w = 0, n_w = 0, mosi_bad = 0, gapcnt = 0, n_done = 0, n_sent = 0;
  logic prev_sck = 0, prev_mosi = 0;

  always @(negedge clk) begin
    if (sck) hcnt++;
    else if (hcnt != 0) begin n_w++; if (hcnt != cur_hp) bad_w++; hcnt = 0; end
    if (rst_n && !cs_n && sck && prev_sck && mosi !== prev_mosi) mosi_bad++;
    prev_sck = sck; prev_mosi = mosi;
    if (cs_n && busy) gapcnt++;
    if (done) begin
      item_t it;
      n_done++;
      if (q.size() == 0) chk(0, "R8 unexpected done", 32'd0, 32'd0);
      else begin
        it = q.pop_front();
        chk(!busy, "R9 busy low with done", {31'd0, busy}, 32'd0);
        chk(nrise == 48, "R10 rising edges", nrise, 48);
        chk(s_cmd == {7'd0, it.wr}, "R2 command byte", s_cmd, {31'd0, it.wr});
        chk(s_addr == it.a, "R2 address byte", s_addr, it.a);
        if (it.wr) chk(s_wdata == it.d, "R3 write data", s_wdata, it.d);
        else chk(rdata == it.d, it.a == 0 ? "R4 id word" : "R4 read data", rdata, it.d);
        chk(bad_w == 0 && n_w == 48, "R6 sck high width", bad_w, 0);
        chk(mosi_bad == 0, "R5 mosi stable while sck high", mosi_bad, 0);
        chk(gapcnt >= 2 * it.hp, "R7 cs gap", gapcnt, 2 * it.hp);
      end
      bad_w = 0; n_w = 0; mosi_bad = 0; gapcnt = 0;
    end
  end

  task automatic xfer(bit wr, logic [7:0] a, logic [31:0] d, logic [7:0] hpin);
    item_t it;
    while (busy) @(negedge clk);
    it.wr = wr; it.a = a; it.hp = (hpin < 4) ? 4 : int'(hpin);
    if (wr) begin it.d = d; if (a != 0) shadow[a] = d; end
    else it.d = (a == 0) ? ID_WORD : shadow[a];
    q.push_back(it);
    cur_hp = it.hp;
    n_sent++;
    rd_wr = wr; addr = a; wdata = d; half_period = hpin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle();
    while (busy || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(cs_n === 1'b1 && sck === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset state",
        {28'd0, cs_n, sck, busy, done}, 32'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    xfer(0, 8'h00, '0, 8'd4);
    xfer(1, 8'h3C, 32'h8000_0001, 8'd4);
    xfer(0, 8'h3C, '0, 8'd4);
    xfer(1, 8'hFF, 32'hA5A5_5A5A, 8'd2);
    xfer(0, 8'hFF, '0, 8'd7);
    xfer(1, 8'h00, 32'h1234_5678, 8'd4);
    xfer(0, 8'h00, '0, 8'd5);
    xfer(0, 8'h81, '0, 8'd4);
    settle();
    // R8: start pulsed mid-frame
    xfer(0, 8'h3C, '0, 8'd4);
    repeat (60) @(negedge clk);
    rd_wr = 1'b1; addr = 8'h11; wdata = 32'hDEAD_BEEF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    settle();
    repeat (900) @(negedge clk);
    chk(n_done == n_sent, "R8 done count", n_done, n_sent);
    chk(smem[8'h11] == init_val(8'h11), "R8 ignored write left register", smem[8'h11], init_val(8'h11));
    xfer(0, 8'h11, '0, 8'd4);
    settle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule